// File: doc/BRIEF.md
# Dual-Context Parallel Port DMA Channel

This block moves bytes between memory and a parallel port device. Software describes each buffer in one of two descriptor slots, A and B. Each slot holds a base address, a byte length and an end-of-transfer flag. Software arms a slot by setting its valid bit in the control register. The channel drains the armed slots in alternating order and clears each valid bit as its buffer completes, so software can refill one slot while the other is being moved.

Memory is reached through a byte-wide request port, with one request outstanding at a time. A read returns its byte on a separate response strobe. A write is finished once it is accepted. The device side has two byte streams with valid/ready handshakes: one toward the device and one from the device. A one-cycle terminal-count pulse tells the device that a buffer flagged as the end of a transfer has fully drained. A one-cycle error pulse reports a descriptor that was rejected and skipped.

Top module: `pp_dma_chan`

## Requirements
- R1: A descriptor register (select 0 = slot A, select 1 = slot B) holds the base address in bits 31:0, the length in bits 43:32 and the end flag in bit 63, and it reads back in the same layout. A write to it is ignored while that slot's valid bit is 1.
- R2: Control register (select 2) bit layout: bit 0 is direction (0 = memory to device, 1 = device to memory), bit 1 is enable, bit 2 is channel reset, bit 4 is the slot A valid bit and bit 3 is the slot B valid bit. Writing 1 to a valid bit arms that slot. Writing 0 to it has no effect.
- R3: In memory-to-device mode, the bytes at base, base+1, …, base+length−1 are presented on the device output stream in that order.
- R4: In device-to-memory mode, successive bytes accepted from the device input stream are written to base, base+1, … in order.
- R5: When a slot with end flag 1 completes, term_cnt pulses high for exactly one cycle. A slot with end flag 0 produces no pulse.
- R6: A slot whose low 12 address bits plus its length exceed 4096 is not transferred. ctx_err pulses for one cycle and the slot's valid bit is cleared. A buffer that ends exactly on the 4 KiB boundary is accepted.
- R7: In device-to-memory mode, a base address whose bits 5:0 are not zero is rejected in the same way as R6. In memory-to-device mode, any byte alignment is accepted.
- R8: After reset, slot A is served first. A completed or rejected slot has its valid bit cleared, and service moves to the other slot, so two armed slots are drained A then B.
- R9: With enable at 0, no memory request is issued and no device handshake completes. The remaining count and the buffer position are held, and the transfer resumes where it stopped once enable returns to 1.
- R10: While control bit 2 is 1, both valid bits, the remaining count and the busy state are cleared, and the slot pointer returns to A.
- R11: The diagnostic register (select 3, read-only) reports the slot in use in bit 0 (0 = A), a busy flag in bit 1 that is 1 only while enabled and processing a buffer, and the bytes left in bits 13:2.
- R12: A slot of length 0 completes without moving any data, and the R5 rule for term_cnt still applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 slot A, 1 slot B, 2 control, 3 diagnostic |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data for reg_sel (combinational) |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 = write request, 0 = read request |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 8 | Memory write byte |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_rvalid | input | 1 | Read response byte valid |
| mem_rdata | input | 8 | Read response byte |
| dev_out_valid | output | 1 | Byte toward the device is valid |
| dev_out_ready | input | 1 | Device accepts the byte |
| dev_out_data | output | 8 | Byte toward the device |
| dev_in_valid | input | 1 | Device byte is valid |
| dev_in_ready | output | 1 | Channel accepts the device byte |
| dev_in_data | input | 8 | Byte from the device |
| term_cnt | output | 1 | One-cycle end-of-transfer pulse |
| ctx_err | output | 1 | One-cycle rejected-descriptor pulse |

## Verification
Register reads are combinational, so the bench samples reg_rdata one time step after it sets reg_sel. A control write is visible in the valid bits right after the edge that takes it. The channel then needs one idle cycle to test the slot and one cycle per completion check. Each memory-to-device byte costs four cycles when the memory and the device never stall. term_cnt and ctx_err rise on the edge after the completion or rejection decision. The bench never counts a fixed number of cycles to find the end of a transfer. It polls the valid bits until they clear and then waits three more cycles before it compares the pulse and byte tallies, which are recorded at every edge. Freeze and reset behaviour is checked by comparing readbacks taken many cycles apart, not single-cycle timing.

// File: rtl/pp_dma_pkg.sv
// Shared constants and the engine state type for the parallel port DMA channel.
// Assumes byte-wide data and a 64-bit register port.
package pp_dma_pkg;
    localparam int BYTE_W    = 8;
    localparam int REG_W     = 64;
    // control register bit positions (software visible)
    localparam int CTL_DIR   = 0;
    localparam int CTL_EN    = 1;
    localparam int CTL_RST   = 2;
    localparam int CTL_VB    = 3;
    localparam int CTL_VA    = 4;
    // descriptor field positions
    localparam int DSC_LEN_LSB = 32;
    localparam int DSC_END     = 63;
    // register selects
    localparam logic [1:0] SEL_DSC_A = 2'd0;
    localparam logic [1:0] SEL_DSC_B = 2'd1;
    localparam logic [1:0] SEL_CTL   = 2'd2;
    localparam logic [1:0] SEL_DIAG  = 2'd3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHK,
        ST_RDREQ,
        ST_RDWAIT,
        ST_PUSH,
        ST_PULL,
        ST_WRREQ
    } eng_st_t;
endpackage

// File: rtl/pp_dma_regs.sv
// Register file: two descriptor slots, the control register with
// set-only valid bits, and the read mux including the diagnostic view.
// Assumes ADDR_W <= 32 and LEN_W <= 30 so the fields fit their 64-bit slots.
module pp_dma_regs
    import pp_dma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    reg_we,
    input  logic [1:0]              reg_sel,
    input  logic [REG_W-1:0]        reg_wdata,
    output logic [REG_W-1:0]        reg_rdata,
    input  logic [1:0]              hw_clr,
    input  logic                    cur_slot,
    input  logic                    busy,
    input  logic [LEN_W-1:0]        remaining,
    output logic [1:0][ADDR_W-1:0]  dsc_base,
    output logic [1:0][LEN_W-1:0]   dsc_len,
    output logic [1:0]              dsc_end,
    output logic [1:0]              slot_valid,
    output logic                    ctl_dir,
    output logic                    ctl_en,
    output logic                    ctl_srst
);
    logic [1:0] set_req;
    logic [1:0] valid_d;
    logic       ctl_wr;
    logic       unused_wbits;

    assign ctl_wr       = reg_we && (reg_sel == SEL_CTL);
    assign unused_wbits = ^{reg_wdata[REG_W-1:DSC_LEN_LSB+LEN_W], reg_wdata[DSC_LEN_LSB-1:ADDR_W]} ^ ^reg_wdata;

    // One descriptor slot per index; written only while its slot is idle.
    for (genvar s = 0; s < 2; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                dsc_base[s] <= '0;
                dsc_len[s]  <= '0;
                dsc_end[s]  <= 1'b0;
            end else if (reg_we && (reg_sel == 2'(s)) && !slot_valid[s]) begin
                dsc_base[s] <= reg_wdata[ADDR_W-1:0];
                dsc_len[s]  <= reg_wdata[DSC_LEN_LSB +: LEN_W];
                dsc_end[s]  <= reg_wdata[DSC_END];
            end
        end
    end

    // Software arm requests, index 0 = slot A, index 1 = slot B.
    assign set_req[0] = ctl_wr && reg_wdata[CTL_VA];
    assign set_req[1] = ctl_wr && reg_wdata[CTL_VB];

    // Next valid: hardware clear beats a re-write of an already set bit.
    always_comb begin
        if (ctl_srst) valid_d = '0;
        else          valid_d = (slot_valid & ~hw_clr) | (set_req & ~slot_valid);
    end

    // Valid bit storage.
    always_ff @(posedge clk) begin
        if (!rst_n) slot_valid <= '0;
        else        slot_valid <= valid_d;
    end

    // Direction, enable and channel reset bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_dir  <= 1'b0;
            ctl_en   <= 1'b0;
            ctl_srst <= 1'b0;
        end else if (ctl_wr) begin
            ctl_dir  <= reg_wdata[CTL_DIR];
            ctl_en   <= reg_wdata[CTL_EN];
            ctl_srst <= reg_wdata[CTL_RST];
        end
    end

    // Read mux for all four registers.
    always_comb begin
        reg_rdata = '0;
        case (reg_sel)
            SEL_DSC_A, SEL_DSC_B: begin
                reg_rdata[ADDR_W-1:0]            = dsc_base[reg_sel[0]];
                reg_rdata[DSC_LEN_LSB +: LEN_W]  = dsc_len[reg_sel[0]];
                reg_rdata[DSC_END]               = dsc_end[reg_sel[0]];
            end
            SEL_CTL: begin
                reg_rdata[CTL_DIR] = ctl_dir;
                reg_rdata[CTL_EN]  = ctl_en;
                reg_rdata[CTL_RST] = ctl_srst;
                reg_rdata[CTL_VB]  = slot_valid[1];
                reg_rdata[CTL_VA]  = slot_valid[0];
            end
            default: begin
                reg_rdata[0]           = cur_slot;
                reg_rdata[1]           = busy && ctl_en;
                reg_rdata[2 +: LEN_W]  = remaining;
            end
        endcase
    end
endmodule

// File: rtl/pp_dma_dsc_check.sv
// Descriptor screen: flags a buffer that would run past a page boundary,
// or an inbound buffer whose base is not on an ALIGN_BITS boundary.
// Purely combinational; assumes PAGE_BITS <= ADDR_W.
module pp_dma_dsc_check #(
    parameter int ADDR_W     = 32,
    parameter int LEN_W      = 12,
    parameter int PAGE_BITS  = 12,
    parameter int ALIGN_BITS = 6
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [LEN_W-1:0]  len,
    input  logic              dir_in,
    output logic              dsc_ok
);
    localparam int SUM_W = ((PAGE_BITS > LEN_W) ? PAGE_BITS : LEN_W) + 1;
    localparam logic [SUM_W-1:0] PAGE_SIZE = SUM_W'(1) << PAGE_BITS;

    logic [SUM_W-1:0] end_off;
    logic             crosses;
    logic             misaligned;
    logic             unused_hi;

    assign unused_hi = ^base[ADDR_W-1:PAGE_BITS];

    // End offset within the page; more than one page means a crossing.
    always_comb begin
        end_off    = SUM_W'(base[PAGE_BITS-1:0]) + SUM_W'(len);
        crosses    = end_off > PAGE_SIZE;
        misaligned = dir_in && (base[ALIGN_BITS-1:0] != '0);
        dsc_ok     = !crosses && !misaligned;
    end
endmodule

// File: rtl/pp_dma_engine.sv
// Transfer engine: selects the slot to serve, screens it, then moves one
// byte at a time. A memory-to-device byte goes read request, read data,
// device push; a device-to-memory byte goes device pull, write request.
// Assumes one memory request in flight and read data arriving later on
// mem_rvalid.
module pp_dma_engine
    import pp_dma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 12
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ctl_en,
    input  logic                   ctl_srst,
    input  logic                   ctl_dir,
    input  logic [1:0]             slot_valid,
    input  logic [1:0][ADDR_W-1:0] dsc_base,
    input  logic [1:0][LEN_W-1:0]  dsc_len,
    input  logic [1:0]             dsc_end,
    input  logic [1:0]             dsc_ok,
    output logic [1:0]             hw_clr,
    output logic                   cur_slot,
    output logic                   busy,
    output logic [LEN_W-1:0]       remaining,
    output logic                   term_cnt,
    output logic                   ctx_err,
    output logic                   mem_req,
    output logic                   mem_we,
    output logic [ADDR_W-1:0]      mem_addr,
    output logic [BYTE_W-1:0]      mem_wdata,
    input  logic                   mem_ready,
    input  logic                   mem_rvalid,
    input  logic [BYTE_W-1:0]      mem_rdata,
    output logic                   dev_out_valid,
    input  logic                   dev_out_ready,
    output logic [BYTE_W-1:0]      dev_out_data,
    input  logic                   dev_in_valid,
    output logic                   dev_in_ready,
    input  logic [BYTE_W-1:0]      dev_in_data
);
    eng_st_t            st;
    logic [ADDR_W-1:0]  ptr;
    logic [LEN_W-1:0]   cnt;
    logic               end_q;
    logic               dir_q;
    logic [BYTE_W-1:0]  hold;
    logic               go;
    logic               reject;
    logic               finish;

    assign go     = ctl_en && !ctl_srst;
    assign reject = go && (st == ST_IDLE) && slot_valid[cur_slot] && !dsc_ok[cur_slot];
    assign finish = go && (st == ST_CHK) && (cnt == '0);

    // Clear request toward the valid bit of the slot being retired.
    always_comb begin
        hw_clr = '0;
        if (reject || finish) hw_clr[cur_slot] = 1'b1;
    end

    // Main sequencer: slot pick, screening, byte movement, completion.
    always_ff @(posedge clk) begin
        if (!rst_n || ctl_srst) begin
            st       <= ST_IDLE;
            cur_slot <= 1'b0;
            ptr      <= '0;
            cnt      <= '0;
            end_q    <= 1'b0;
            dir_q    <= 1'b0;
            hold     <= '0;
            term_cnt <= 1'b0;
            ctx_err  <= 1'b0;
        end else begin
            term_cnt <= 1'b0;
            ctx_err  <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (go) begin
                        if (slot_valid[cur_slot]) begin
                            if (dsc_ok[cur_slot]) begin
                                ptr   <= dsc_base[cur_slot];
                                cnt   <= dsc_len[cur_slot];
                                end_q <= dsc_end[cur_slot];
                                dir_q <= ctl_dir;
                                st    <= ST_CHK;
                            end else begin
                                ctx_err  <= 1'b1;
                                cur_slot <= !cur_slot;
                            end
                        end else if (slot_valid[!cur_slot]) begin
                            cur_slot <= !cur_slot;
                        end
                    end
                end
                ST_CHK: begin
                    if (go) begin
                        if (cnt == '0) begin
                            term_cnt <= end_q;
                            cur_slot <= !cur_slot;
                            st       <= ST_IDLE;
                        end else begin
                            st <= dir_q ? ST_PULL : ST_RDREQ;
                        end
                    end
                end
                ST_RDREQ: begin
                    if (go && mem_ready) st <= ST_RDWAIT;
                end
                ST_RDWAIT: begin
                    if (mem_rvalid) begin
                        hold <= mem_rdata;
                        st   <= ST_PUSH;
                    end
                end
                ST_PUSH: begin
                    if (go && dev_out_ready) begin
                        cnt <= cnt - LEN_W'(1);
                        ptr <= ptr + ADDR_W'(1);
                        st  <= ST_CHK;
                    end
                end
                ST_PULL: begin
                    if (go && dev_in_valid) begin
                        hold <= dev_in_data;
                        st   <= ST_WRREQ;
                    end
                end
                ST_WRREQ: begin
                    if (go && mem_ready) begin
                        cnt <= cnt - LEN_W'(1);
                        ptr <= ptr + ADDR_W'(1);
                        st  <= ST_CHK;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Handshake outputs, all gated by enable so a frozen channel is silent.
    always_comb begin
        mem_req       = go && ((st == ST_RDREQ) || (st == ST_WRREQ));
        mem_we        = (st == ST_WRREQ);
        mem_addr      = ptr;
        mem_wdata     = hold;
        dev_out_valid = go && (st == ST_PUSH);
        dev_out_data  = hold;
        dev_in_ready  = go && (st == ST_PULL);
        busy          = (st != ST_IDLE);
        remaining     = cnt;
    end
endmodule

// File: rtl/pp_dma_chan.sv
// Top of the dual-slot parallel port DMA channel: register file, one
// descriptor screen per slot and the transfer engine.
// Assumes a synchronous active-low reset and software that arms a slot
// only after filling its descriptor.
module pp_dma_chan
    import pp_dma_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LEN_W      = 12,
    parameter int PAGE_BITS  = 12,
    parameter int ALIGN_BITS = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_sel,
    input  logic [63:0]       reg_wdata,
    output logic [63:0]       reg_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic              mem_ready,
    input  logic              mem_rvalid,
    input  logic [7:0]        mem_rdata,
    output logic              dev_out_valid,
    input  logic              dev_out_ready,
    output logic [7:0]        dev_out_data,
    input  logic              dev_in_valid,
    output logic              dev_in_ready,
    input  logic [7:0]        dev_in_data,
    output logic              term_cnt,
    output logic              ctx_err
);
    logic [1:0][ADDR_W-1:0] dsc_base;
    logic [1:0][LEN_W-1:0]  dsc_len;
    logic [1:0]             dsc_end;
    logic [1:0]             dsc_ok;
    logic [1:0]             slot_valid;
    logic [1:0]             hw_clr;
    logic                   ctl_dir;
    logic                   ctl_en;
    logic                   ctl_srst;
    logic                   cur_slot;
    logic                   busy;
    logic [LEN_W-1:0]       remaining;

    pp_dma_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_we     (reg_we),
        .reg_sel    (reg_sel),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .hw_clr     (hw_clr),
        .cur_slot   (cur_slot),
        .busy       (busy),
        .remaining  (remaining),
        .dsc_base   (dsc_base),
        .dsc_len    (dsc_len),
        .dsc_end    (dsc_end),
        .slot_valid (slot_valid),
        .ctl_dir    (ctl_dir),
        .ctl_en     (ctl_en),
        .ctl_srst   (ctl_srst)
    );

    for (genvar s = 0; s < 2; s++) begin : g_screen
        pp_dma_dsc_check #(
            .ADDR_W(ADDR_W), .LEN_W(LEN_W),
            .PAGE_BITS(PAGE_BITS), .ALIGN_BITS(ALIGN_BITS)
        ) u_screen (
            .base   (dsc_base[s]),
            .len    (dsc_len[s]),
            .dir_in (ctl_dir),
            .dsc_ok (dsc_ok[s])
        );
    end

    pp_dma_engine #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_eng (
        .clk           (clk),
        .rst_n         (rst_n),
        .ctl_en        (ctl_en),
        .ctl_srst      (ctl_srst),
        .ctl_dir       (ctl_dir),
        .slot_valid    (slot_valid),
        .dsc_base      (dsc_base),
        .dsc_len       (dsc_len),
        .dsc_end       (dsc_end),
        .dsc_ok        (dsc_ok),
        .hw_clr        (hw_clr),
        .cur_slot      (cur_slot),
        .busy          (busy),
        .remaining     (remaining),
        .term_cnt      (term_cnt),
        .ctx_err       (ctx_err),
        .mem_req       (mem_req),
        .mem_we        (mem_we),
        .mem_addr      (mem_addr),
        .mem_wdata     (mem_wdata),
        .mem_ready     (mem_ready),
        .mem_rvalid    (mem_rvalid),
        .mem_rdata     (mem_rdata),
        .dev_out_valid (dev_out_valid),
        .dev_out_ready (dev_out_ready),
        .dev_out_data  (dev_out_data),
        .dev_in_valid  (dev_in_valid),
        .dev_in_ready  (dev_in_ready),
        .dev_in_data   (dev_in_data)
    );
endmodule

// File: rtl/pp_dma_chan_chk.sv
// Property checker for pp_dma_chan, attached to every instance by bind.
// Observes the control bits, the valid bits and the engine state.
module pp_dma_chan_chk #(
    parameter int LEN_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ctl_en,
    input logic             ctl_srst,
    input logic [1:0]       slot_valid,
    input logic             busy,
    input logic [LEN_W-1:0] remaining,
    input logic             term_cnt,
    input logic             ctx_err,
    input logic             mem_req,
    input logic             dev_out_valid,
    input logic             dev_out_ready,
    input logic [7:0]       dev_out_data,
    input logic             dev_in_ready
);
    // R5
    tc_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        term_cnt |=> !term_cnt);

    // R6
    err_tc_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({term_cnt, ctx_err}));

    // R9
    frozen_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_en |-> (!mem_req && !dev_out_valid && !dev_in_ready));

    // R9
    frozen_count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_en && !ctl_srst) |=> $stable(remaining));

    // R10
    srst_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_srst |=> (slot_valid == 2'b00 && !busy && remaining == '0));

    // R3
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_out_valid && !dev_out_ready && ctl_en && !ctl_srst) |=>
        (!ctl_en || ctl_srst || (dev_out_valid && $stable(dev_out_data))));
endmodule

bind pp_dma_chan pp_dma_chan_chk #(.LEN_W(LEN_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ctl_en        (ctl_en),
    .ctl_srst      (ctl_srst),
    .slot_valid    (slot_valid),
    .busy          (busy),
    .remaining     (remaining),
    .term_cnt      (term_cnt),
    .ctx_err       (ctx_err),
    .mem_req       (mem_req),
    .dev_out_valid (dev_out_valid),
    .dev_out_ready (dev_out_ready),
    .dev_out_data  (dev_out_data),
    .dev_in_ready  (dev_in_ready)
);

// File: tb/sim_pp_dma_chan.sv
module sim_pp_dma_chan;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_ready = 1'b1;
    logic        mem_rvalid = 1'b0;
    logic [7:0]  mem_rdata = '0;
    logic        dev_out_valid;
    logic        dev_out_ready = 1'b1;
    logic [7:0]  dev_out_data;
    logic        dev_in_valid = 1'b1;
    logic        dev_in_ready;
    logic [7:0]  in_seq = 8'h30;
    logic        term_cnt, ctx_err;

    int checks = 0;
    int failures = 0;
    int out_n = 0, wr_n = 0, tc_n = 0, err_n = 0;
    logic [7:0]  out_log [0:255];
    logic [31:0] wr_addr [0:255];
    logic [7:0]  wr_data [0:255];

    always #10 clk = !clk;

    pp_dma_chan u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .dev_out_valid(dev_out_valid),
        .dev_out_ready(dev_out_ready), .dev_out_data(dev_out_data),
        .dev_in_valid(dev_in_valid), .dev_in_ready(dev_in_ready),
        .dev_in_data(in_seq), .term_cnt(term_cnt), .ctx_err(ctx_err)
    );

    function automatic logic [7:0] mem_byte(input logic [31:0] a);
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction

    function automatic logic [63:0] dsc(input logic last, input int len, input logic [31:0] base);
        return {last, 19'd0, 12'(len), base};
    endfunction

    // Memory, device and pulse models, all sampled at the clock edge.
    always @(posedge clk) begin
        mem_rvalid <= mem_req && !mem_we && mem_ready;
        mem_rdata  <= mem_byte(mem_addr);
        if (mem_req && mem_we && mem_ready) begin
            wr_addr[wr_n[7:0]] <= mem_addr;
            wr_data[wr_n[7:0]] <= mem_wdata;
            wr_n <= wr_n + 1;
        end
        if (dev_out_valid && dev_out_ready) begin
            out_log[out_n[7:0]] <= dev_out_data;
            out_n <= out_n + 1;
        end
        if (dev_in_valid && dev_in_ready) in_seq <= in_seq + 8'd1;
        if (term_cnt) tc_n <= tc_n + 1;
        if (ctx_err) err_n <= err_n + 1;
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [63:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = s; reg_wdata = d;
        @(posedge clk);
        #1 reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] s, output logic [63:0] d);
        @(negedge clk);
        reg_we = 1'b0; reg_sel = s;
        #1 d = reg_rdata;
    endtask

    task automatic wait_idle(input string req);
        logic [63:0] v;
        int n = 0;
        rd(2'd2, v);
        while (v[4:3] != 2'b00 && n < 5000) begin
            rd(2'd2, v);
            n++;
        end
        chk(req, {63'd0, n >= 5000}, 64'd0);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [63:0] v, v2;
        int o0, t0, e0, w0, n1;
        logic [7:0] s0;
        logic [31:0] b;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // reset state
        rd(2'd2, v); chk("R2 ctl after reset", v, 64'd0);
        rd(2'd3, v); chk("R11 diag after reset", v, 64'd0);
        rd(2'd0, v); chk("R1 slot A after reset", v, 64'd0);

        // R1 field layout readback
        wr(2'd0, dsc(1'b1, 12'hABC, 32'h1234_5678));
        rd(2'd0, v); chk("R1 slot A readback", v, dsc(1'b1, 12'hABC, 32'h1234_5678));
        wr(2'd1, dsc(1'b0, 7, 32'h0000_0FF9));
        rd(2'd1, v); chk("R1 slot B readback", v, dsc(1'b0, 7, 32'h0000_0FF9));

        // R3 R5 R7: outbound sweep over offsets and lengths
        for (int off = 0; off < 4; off++) begin
            for (int len = 1; len <= 4; len++) begin
                b = 32'h100 + 32'(off * 16);
                b = b + 32'(off);
                o0 = out_n; t0 = tc_n;
                wr(2'd0, dsc(len[0], len, b));
                wr(2'd2, 64'h12);
                wr_dummy: begin end
                wait_idle("R8 outbound completes");
                chk("R3 outbound byte count", 64'(out_n - o0), 64'(len));
                for (int i = 0; i < len; i++)
                    chk("R3 R7 outbound byte", 64'(out_log[(o0 + i) % 256]), 64'(mem_byte(b + 32'(i))));
                chk("R5 term pulse per end flag", 64'(tc_n - t0), 64'(len[0]));
                rd(2'd3, v); chk("R11 diag idle after done", 64'(v[13:1]), 64'd0);
            end
        end

        // R4: inbound sweep
        for (int k = 0; k < 2; k++) begin
            for (int len = 1; len <= 3; len++) begin
                b = 32'h200 + 32'(k * 64);
                w0 = wr_n; s0 = in_seq;
                wr(2'd0, dsc(1'b0, len, b));
                wr(2'd2, 64'h13);
                wait_idle("R8 inbound completes");
                chk("R4 inbound write count", 64'(wr_n - w0), 64'(len));
                for (int i = 0; i < len; i++) begin
                    chk("R4 inbound address", 64'(wr_addr[(w0 + i) % 256]), 64'(b + 32'(i)));
                    chk("R4 inbound data", 64'(wr_data[(w0 + i) % 256]), 64'(s0 + 8'(i)));
                end
            end
        end

        // R6: ends exactly on boundary accepted, one past rejected
        o0 = out_n; e0 = err_n;
        wr(2'd0, dsc(1'b0, 2, 32'h0000_1FFE));
        wr(2'd2, 64'h12);
        wait_idle("R6 boundary buffer completes");
        chk("R6 boundary buffer moves", 64'(out_n - o0), 64'd2);
        chk("R6 boundary buffer no error", 64'(err_n - e0), 64'd0);
        o0 = out_n; e0 = err_n;
        wr(2'd0, dsc(1'b0, 2, 32'h0000_1FFF));
        wr(2'd2, 64'h12);
        wait_idle("R6 crossing buffer retired");
        chk("R6 crossing buffer error pulse", 64'(err_n - e0), 64'd1);
        chk("R6 crossing buffer no data", 64'(out_n - o0), 64'd0);
        rd(2'd2, v); chk("R6 valid cleared", 64'(v[4:3]), 64'd0);

        // R7: misaligned inbound rejected
        w0 = wr_n; e0 = err_n;
        wr(2'd0, dsc(1'b0, 1, 32'h0000_0201));
        wr(2'd2, 64'h13);
        wait_idle("R7 misaligned retired");
        chk("R7 misaligned inbound error", 64'(err_n - e0), 64'd1);
        chk("R7 misaligned inbound no write", 64'(wr_n - w0), 64'd0);

        // R12: zero length with and without end flag
        o0 = out_n; t0 = tc_n;
        wr(2'd0, dsc(1'b1, 0, 32'h0000_0700));
        wr(2'd2, 64'h12);
        wait_idle("R12 zero length completes");
        chk("R12 zero length end flag pulses", 64'(tc_n - t0), 64'd1);
        chk("R12 zero length no data", 64'(out_n - o0), 64'd0);
        t0 = tc_n;
        wr(2'd0, dsc(1'b0, 0, 32'h0000_0700));
        wr(2'd2, 64'h12);
        wait_idle("R12 zero length completes");
        chk("R12 zero length no flag no pulse", 64'(tc_n - t0), 64'd0);

        // R10 then R8: channel reset returns to slot A, two slots in order
        wr(2'd2, 64'h04);
        wr(2'd2, 64'h00);
        rd(2'd3, v); chk("R10 slot pointer back to A", 64'(v[0]), 64'd0);
        o0 = out_n;
        wr(2'd0, dsc(1'b0, 2, 32'h300));
        wr(2'd1, dsc(1'b0, 3, 32'h400));
        wr(2'd2, 64'h1A);
        wait_idle("R8 both slots complete");
        chk("R8 total bytes", 64'(out_n - o0), 64'd5);
        for (int i = 0; i < 2; i++)
            chk("R8 slot A first", 64'(out_log[(o0 + i) % 256]), 64'(mem_byte(32'h300 + 32'(i))));
        for (int i = 0; i < 3; i++)
            chk("R8 slot B second", 64'(out_log[(o0 + 2 + i) % 256]), 64'(mem_byte(32'h400 + 32'(i))));
        rd(2'd3, v); chk("R11 slot pointer after two", 64'(v[0]), 64'd0);

        // R1 R2 R9: armed but disabled, descriptor locked
        wr(2'd2, 64'h00);
        wr(2'd0, dsc(1'b1, 20, 32'h500));
        wr(2'd2, 64'h10);
        rd(2'd2, v); chk("R2 arm readback", v, 64'h10);
        wr(2'd0, dsc(1'b0, 5, 32'h999));
        rd(2'd0, v); chk("R1 write ignored while valid", v, dsc(1'b1, 20, 32'h500));
        o0 = out_n; t0 = tc_n;
        repeat (10) @(negedge clk);
        chk("R9 no start while disabled", 64'(out_n - o0), 64'd0);
        wr(2'd2, 64'h12);
        repeat (12) @(negedge clk);
        rd(2'd3, v);
        chk("R11 busy while processing", 64'(v[1]), 64'd1);
        chk("R11 count in flight", 64'((v[13:2] > 0) && (v[13:2] < 20)), 64'd1);
        wr(2'd2, 64'h10);
        rd(2'd3, v); n1 = out_n;
        repeat (20) @(negedge clk);
        rd(2'd3, v2);
        chk("R9 count held while frozen", 64'(v2[13:2]), 64'(v[13:2]));
        chk("R9 no bytes while frozen", 64'(out_n), 64'(n1));
        chk("R11 busy low while frozen", 64'(v2[1]), 64'd0);
        wr(2'd2, 64'h12);
        wait_idle("R9 resumed transfer completes");
        chk("R9 resumed total bytes", 64'(out_n - o0), 64'd20);
        for (int i = 0; i < 20; i++)
            chk("R9 resumed byte", 64'(out_log[(o0 + i) % 256]), 64'(mem_byte(32'h500 + 32'(i))));
        chk("R5 pulse after resumed end buffer", 64'(tc_n - t0), 64'd1);

        // R10: channel reset mid-transfer
        wr(2'd0, dsc(1'b1, 30, 32'h600));
        wr(2'd1, dsc(1'b0, 4, 32'h680));
        wr(2'd2, 64'h1A);
        repeat (10) @(negedge clk);
        t0 = tc_n;
        wr(2'd2, 64'h06);
        repeat (2) @(negedge clk);
        rd(2'd2, v); chk("R10 valids cleared", v, 64'h06);
        rd(2'd3, v); chk("R10 diag cleared", v, 64'd0);
        wr(2'd2, 64'h00);
        repeat (5) @(negedge clk);
        chk("R10 no pulse after reset", 64'(tc_n - t0), 64'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule